// File: doc/BRIEF.md
# Multi-Lane Training Word Aligner

This block follows the per-lane deserialisers of a source-synchronous video link. On every word clock it receives one parallel word per lane. During training, every lane carries the same fixed word. The block works in two strict stages.

In the first stage, each lane searches for its word boundary independently. It compares the received word against the training word. On a mismatch it sends a one-cycle bitslip request to its deserialiser, then waits a settling time before it compares again. A lane is word-locked once the training word has arrived on a run of consecutive words with no slip in between.

The second stage starts only after every lane is word-locked. Each lane then watches for its first word that is not the training word, called the marker. The block records the cycle in which each marker arrives. It delays every lane by whole words so that all markers line up with the latest one. It then raises `locked` and passes the aligned words through. A synchronous restart input clears the whole procedure.

Top module: `lane_aligner_top`

## Requirements
- R1: After reset, `locked`, `lane_locked` and `slip_req` are all low.
- R2: A bitslip request is a single-cycle pulse. After a pulse, the lane makes no comparison and raises no request for SETTLE (default 4) word clocks, so consecutive requests on a searching lane are exactly SETTLE+1 cycles apart. The number of requests a lane issues before it locks equals the number of one-bit rotations its input needs to show the training word 12'b111111000000.
- R3: A lane raises its `lane_locked` bit on the 8th consecutive clock in which it sees the training word, and not earlier.
- R4: If a lane has issued 12 requests since its last error (or restart) and still sees a mismatch, it pulses its `slip_err` bit for one cycle instead of slipping, and then starts a new search of 12 requests.
- R5: Once set, a `lane_locked` bit stays high until restart or reset.
- R6: Lane deskew starts only when all lanes are word-locked. While every lane keeps sending the training word, `locked` stays low.
- R7: After `locked` rises, all lanes of `aligned_words` carry the same source word in the same cycle, for lane skews of up to 7 words. Each lane's delay is the latest marker arrival cycle minus that lane's own marker arrival cycle, limited to 7.
- R8: `locked` is high only while every `lane_locked` bit is high.
- R9: A one-cycle `restart` pulse clears `locked`, every `lane_locked` bit and any pending request by the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of the whole training procedure |
| rx_words | input | 96 | Deserialised words, lane n in bits [12n+11:12n] |
| slip_req | output | 8 | One-cycle bitslip request per lane |
| slip_err | output | 8 | One-cycle pulse: lane exhausted its 12 slip attempts |
| lane_locked | output | 8 | Lane has found its word boundary |
| locked | output | 1 | All lanes word-locked and deskewed |
| aligned_words | output | 96 | Lane words after deskew delay, same packing as rx_words |

## Verification
A lane whose boundary state machine is corrupted shows up at the ports within one settling window. The bitslip request count or spacing no longer matches the rotation the stimulus needs, or `lane_locked` rises one cycle early or late. An attempt counter with the wrong size moves the error pulse away from the 12th request. A wrong marker timestamp or delay selection does not disturb locking. Instead, it appears in the first data words after `locked` rises, as lanes in `aligned_words` that differ from each other or skip a value in sequence.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_LOCK   = 2'd2
   } bnd_state_t;

endpackage

// File: rtl/lane_boundary.sv
module lane_boundary
   import lane_align_pkg::*;
#(
   parameter int                 WIDTH    = 12,
   parameter logic [WIDTH-1:0]   TRAIN    = 12'b111111000000,
   parameter int                 SETTLE   = 4,
   parameter int                 LOCK_RUN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [WIDTH-1:0] word,
   output logic             slip,
   output logic             err,
   output logic             locked
);
   localparam int ATT_W = $clog2(WIDTH + 1);
   localparam int SET_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
   localparam int RUN_W = $clog2(LOCK_RUN);
   localparam logic [ATT_W-1:0] ATT_MAX  = ATT_W'(WIDTH);
   localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE - 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

   if (SETTLE < 1)   begin : g_bad_settle $error("SETTLE must be at least 1"); end
   if (LOCK_RUN < 2) begin : g_bad_run    $error("LOCK_RUN must be at least 2"); end

   bnd_state_t       st;
   logic [ATT_W-1:0] att;
   logic [SET_W-1:0] wait_cnt;
   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_HUNT; att <= '0; wait_cnt <= '0; run <= '0;
         slip <= 1'b0; err <= 1'b0;
      end else if (restart) begin
         st <= ST_HUNT; att <= '0; wait_cnt <= '0; run <= '0;
         slip <= 1'b0; err <= 1'b0;
      end else begin
         slip <= 1'b0;
         err  <= 1'b0;
         unique case (st)
            ST_HUNT: begin
               if (word == TRAIN) begin
                  if (run == RUN_LAST) st <= ST_LOCK;
                  else                 run <= run + 1'b1;
               end else begin
                  run <= '0;
                  if (att == ATT_MAX) begin
                     err <= 1'b1;
                     att <= '0;
                  end else begin
                     slip     <= 1'b1;
                     att      <= att + 1'b1;
                     wait_cnt <= SET_LOAD;
                     st       <= ST_SETTLE;
                  end
               end
            end
            ST_SETTLE: begin
               if (wait_cnt == '0) st <= ST_HUNT;
               else                wait_cnt <= wait_cnt - 1'b1;
            end
            default: st <= ST_LOCK;
         endcase
      end
   end

   assign locked = (st == ST_LOCK);

   // R2
   slip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) slip |=> !slip);
   // R4
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);
   // R4
   att_range_chk: assert property (@(posedge clk) disable iff (!rst_n) att <= ATT_MAX);
   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(restart));
   // R2
   lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |-> !slip);
endmodule

// File: rtl/lane_delay.sv
module lane_delay #(
   parameter int WIDTH   = 12,
   parameter int MAX_DLY = 7,
   parameter int DLY_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic [DLY_W-1:0] sel,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] pick;

   if (MAX_DLY == 0) begin : g_pass
      assign pick = din;
   end else begin : g_line
      logic [WIDTH-1:0] stage [MAX_DLY];
      always_ff @(posedge clk) begin
         stage[0] <= din;
         for (int k = 1; k < MAX_DLY; k++) stage[k] <= stage[k-1];
      end
      always_comb begin
         pick = din;
         for (int k = 0; k < MAX_DLY; k++)
            if (sel == DLY_W'(k + 1)) pick = stage[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else        dout <= pick;
   end

   // R7
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n) sel <= DLY_W'(MAX_DLY));
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew #(
   parameter int               LANES   = 8,
   parameter int               WIDTH   = 12,
   parameter logic [WIDTH-1:0] TRAIN   = 12'b111111000000,
   parameter int               MAX_DLY = 7,
   parameter int               DLY_W   = 3,
   parameter int               TS_W    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic                   start,
   input  logic [LANES*WIDTH-1:0] words,
   output logic [LANES*DLY_W-1:0] dly,
   output logic                   done
);
   localparam logic [TS_W-1:0] TS_TOP  = '1;
   localparam logic [TS_W-1:0] DLY_CAP = TS_W'(MAX_DLY);

   if (TS_W < DLY_W) begin : g_bad_ts $error("TS_W must cover the delay range"); end

   logic [WIDTH-1:0] prev [LANES];
   logic [TS_W-1:0]  ts   [LANES];
   logic [LANES-1:0] seen;
   logic [TS_W-1:0]  cnt;
   logic [TS_W-1:0]  tmax;
   logic [LANES*DLY_W-1:0] dly_calc;

   always_comb begin
      tmax = '0;
      for (int i = 0; i < LANES; i++)
         if (ts[i] > tmax) tmax = ts[i];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_calc
      logic [TS_W-1:0] diff;
      assign diff = tmax - ts[i];
      assign dly_calc[i*DLY_W +: DLY_W] = (diff > DLY_CAP) ? DLY_W'(MAX_DLY) : diff[DLY_W-1:0];
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) prev[i] <= words[i*WIDTH +: WIDTH];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= '0; cnt <= '0; done <= 1'b0; dly <= '0;
         for (int i = 0; i < LANES; i++) ts[i] <= '0;
      end else if (restart) begin
         seen <= '0; cnt <= '0; done <= 1'b0; dly <= '0;
         for (int i = 0; i < LANES; i++) ts[i] <= '0;
      end else if (start && !done) begin
         if (cnt != TS_TOP) cnt <= cnt + 1'b1;
         for (int i = 0; i < LANES; i++) begin
            if (!seen[i] && prev[i] == TRAIN && words[i*WIDTH +: WIDTH] != TRAIN) begin
               seen[i] <= 1'b1;
               ts[i]   <= cnt;
            end
         end
         if (&seen) begin
            done <= 1'b1;
            dly  <= dly_calc;
         end
      end
   end

   // R6
   stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(start));
   // R9
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !done && dly == '0);
endmodule

// File: rtl/lane_aligner_top.sv
module lane_aligner_top #(
   parameter int               LANES    = 8,
   parameter int               WIDTH    = 12,
   parameter logic [WIDTH-1:0] TRAIN    = 12'b111111000000,
   parameter int               SETTLE   = 4,
   parameter int               LOCK_RUN = 8,
   parameter int               MAX_DLY  = 7,
   parameter int               TS_W     = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic [LANES*WIDTH-1:0] rx_words,
   output logic [LANES-1:0]       slip_req,
   output logic [LANES-1:0]       slip_err,
   output logic [LANES-1:0]       lane_locked,
   output logic                   locked,
   output logic [LANES*WIDTH-1:0] aligned_words
);
   localparam int DLY_W = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1;

   if (LANES < 1) begin : g_bad_lanes $error("LANES must be at least 1"); end
   if (WIDTH < 2) begin : g_bad_width $error("WIDTH must be at least 2"); end

   logic [LANES*DLY_W-1:0] dly;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_boundary #(
         .WIDTH(WIDTH), .TRAIN(TRAIN), .SETTLE(SETTLE), .LOCK_RUN(LOCK_RUN)
      ) bnd_i (
         .clk(clk), .rst_n(rst_n), .restart(restart),
         .word(rx_words[i*WIDTH +: WIDTH]),
         .slip(slip_req[i]), .err(slip_err[i]), .locked(lane_locked[i])
      );
      lane_delay #(
         .WIDTH(WIDTH), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)
      ) dly_i (
         .clk(clk), .rst_n(rst_n),
         .din(rx_words[i*WIDTH +: WIDTH]),
         .sel(dly[i*DLY_W +: DLY_W]),
         .dout(aligned_words[i*WIDTH +: WIDTH])
      );
   end

   lane_deskew #(
      .LANES(LANES), .WIDTH(WIDTH), .TRAIN(TRAIN),
      .MAX_DLY(MAX_DLY), .DLY_W(DLY_W), .TS_W(TS_W)
   ) dsk_i (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .start(&lane_locked), .words(rx_words),
      .dly(dly), .done(locked)
   );

   // R8
   lock_all_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |-> &lane_locked);
   // R9
   restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !locked && lane_locked == '0 && slip_req == '0);
endmodule

// File: tb/lane_aligner_top_tb_top.sv
`timescale 1ns/1ps
module lane_aligner_top_tb_top;
   localparam int L = 8;
   localparam int W = 12;
   localparam logic [W-1:0] TRN = 12'b111111000000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0;
   logic [L*W-1:0] rx_words;
   logic [L-1:0] slip_req, slip_err, lane_locked;
   logic locked;
   logic [L*W-1:0] aligned_words;

   int checks = 0, errors = 0;
   int cyc = 0;
   int off [L];
   int skew [L];
   int slips [L];
   bit data_on = 0;
   int data_start = 0;
   int bad_lane = -1;
   int err_seen = 0, slips_at_err = 0;
   int last_slip = 0, gap_bad = 0, gap_cnt = 0;

   always #2.5 clk = ~clk;

   lane_aligner_top dut_i (
      .clk(clk), .rst_n(rst_n), .restart(restart), .rx_words(rx_words),
      .slip_req(slip_req), .slip_err(slip_err), .lane_locked(lane_locked),
      .locked(locked), .aligned_words(aligned_words)
   );

   function automatic logic [W-1:0] rotl(logic [W-1:0] w, int n);
      logic [2*W-1:0] d;
      d = {w, w} << n;
      return d[2*W-1:W];
   endfunction

   always @(posedge clk) begin
      cyc++;
      for (int i = 0; i < L; i++)
         if (slip_req[i]) begin off[i] = (off[i] + 1) % W; slips[i]++; end
      if (bad_lane >= 0) begin
         if (slip_req[bad_lane]) begin
            if (slips[bad_lane] > 1 && slips[bad_lane] <= W) begin
               gap_cnt++;
               if (cyc - last_slip != 5) gap_bad++;
            end
            last_slip = cyc;
         end
         if (slip_err[bad_lane]) begin
            err_seen++;
            if (err_seen == 1) slips_at_err = slips[bad_lane];
         end
      end
   end

   always @(negedge clk) begin
      for (int i = 0; i < L; i++) begin
         logic [W-1:0] src;
         int n;
         n = cyc - data_start - skew[i];
         if (i == bad_lane)         src = 12'hABC;
         else if (!data_on || n < 0) src = TRN;
         else                        src = 12'h200 | W'(n & 63);
         rx_words[i*W +: W] = rotl(src, off[i]);
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_restart();
      @(negedge clk) restart = 1'b1;
      @(negedge clk) restart = 1'b0;
   endtask

   task automatic wait_all_locked(input int limit, output bit ok);
      ok = 0;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         if (&lane_locked) begin ok = 1; break; end
      end
   endtask

   task automatic t_reset();
      chk(locked == 1'b0, "R1 locked", int'(locked), 0);
      chk(lane_locked == '0, "R1 lane_locked", int'(lane_locked), 0);
      chk(slip_req == '0, "R1 slip_req", int'(slip_req), 0);
   endtask

   task automatic t_lock_run();
      pulse_restart();
      repeat (7) @(posedge clk);
      @(negedge clk);
      chk(lane_locked == '0, "R3 early lock", int'(lane_locked), 0);
      @(posedge clk);
      @(negedge clk);
      chk(&lane_locked, "R3 lock on 8th match", int'(lane_locked), 255);
      chk(slip_req == '0, "R2 no slips when aligned", int'(slip_req), 0);
   endtask

   task automatic t_slip_search();
      bit ok;
      int init [L] = '{5, 11, 1, 0, 7, 3, 9, 2};
      @(negedge clk);
      for (int i = 0; i < L; i++) begin off[i] = init[i]; slips[i] = 0; end
      pulse_restart();
      wait_all_locked(500, ok);
      chk(ok, "R2 all lanes lock after search", int'(lane_locked), 255);
      for (int i = 0; i < L; i++)
         chk(slips[i] == (W - init[i]) % W, "R2 slip count", slips[i], (W - init[i]) % W);
      chk(slip_err == '0, "R4 no error on good lanes", int'(slip_err), 0);
   endtask

   task automatic t_stage_order();
      bit held = 1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (locked) held = 0;
      end
      chk(held, "R6 no lock without marker", int'(locked), 0);
      chk(&lane_locked, "R5 lane locks held", int'(lane_locked), 255);
   endtask

   task automatic t_deskew();
      int sk [L] = '{0, 3, 7, 1, 5, 2, 6, 4};
      bit ok = 0, held = 1;
      logic [W-1:0] prev0;
      @(negedge clk);
      for (int i = 0; i < L; i++) skew[i] = sk[i];
      data_start = cyc + 2;
      data_on = 1;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (!(&lane_locked)) held = 0;
         if (locked) begin ok = 1; break; end
      end
      chk(ok, "R7 locked after markers", int'(locked), 1);
      chk(held, "R5 lane locks held in deskew", int'(lane_locked), 255);
      repeat (2) @(negedge clk);
      prev0 = aligned_words[W-1:0];
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         for (int i = 1; i < L; i++)
            if (aligned_words[i*W +: W] != aligned_words[W-1:0])
               chk(0, "R7 lanes aligned", int'(aligned_words[i*W +: W]), int'(aligned_words[W-1:0]));
         if (aligned_words[W-1:0] != prev0 + 1'b1)
            chk(0, "R7 sequence continuous", int'(aligned_words[W-1:0]), int'(prev0 + 1'b1));
         chk(locked && (&lane_locked), "R8 locked with all lanes", int'(lane_locked), 255);
         prev0 = aligned_words[W-1:0];
      end
      chk(prev0[W-1:6] == 6'b001000, "R7 data reached output", int'(prev0), 12'h200);
   endtask

   task automatic t_restart();
      pulse_restart();
      chk(locked == 1'b0, "R9 locked cleared", int'(locked), 0);
      chk(lane_locked == '0, "R9 lane locks cleared", int'(lane_locked), 0);
      chk(slip_req == '0, "R9 no pending slip", int'(slip_req), 0);
      @(negedge clk);
      data_on = 0;
      for (int i = 0; i < L; i++) skew[i] = 0;
   endtask

   task automatic t_error();
      bit ok = 0;
      @(negedge clk);
      for (int i = 0; i < L; i++) slips[i] = 0;
      bad_lane = 3;
      err_seen = 0; gap_bad = 0; gap_cnt = 0;
      pulse_restart();
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (err_seen > 0) begin ok = 1; break; end
      end
      chk(ok, "R4 error pulse seen", err_seen, 1);
      chk(slips_at_err == 12, "R4 slips before error", slips_at_err, 12);
      chk(gap_cnt == 11 && gap_bad == 0, "R2 settle spacing", gap_bad, 0);
      chk(lane_locked[3] == 1'b0 && !locked, "R4 lane stays unlocked", int'(lane_locked), 247);
      for (int k = 0; k < 400 && err_seen < 2; k++) @(negedge clk);
      chk(slips[3] == 24, "R4 search restarts", slips[3], 24);
      @(negedge clk);
      bad_lane = -1;
      pulse_restart();
      wait_all_locked(500, ok);
      chk(ok, "R9 relock after restart", int'(lane_locked), 255);
   endtask

   initial begin
      for (int i = 0; i < L; i++) begin off[i] = 0; skew[i] = 0; slips[i] = 0; end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_lock_run();
      t_slip_search();
      t_stage_order();
      t_deskew();
      t_restart();
      t_error();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule